// File: doc/BRIEF.md
# Stereo Digital Silence Detector

This block watches a stereo stream of signed audio samples. Each sample-valid strobe carries one left word and one right word. Each channel keeps its own count of back-to-back zero-valued samples. Once a channel has seen a run of `RUN_LEN` zeros (1024 by default), it is declared silent. The first nonzero sample on that channel makes it active again. Two flag lines report the result. They can be used to drive an external mute or as status lines.

A mode input picks how the flags are formed. In per-channel form, each flag follows its own channel. In joint form, both flags show the same value, which is asserted only while both channels are silent. A polarity input chooses whether a flag is high or low to signal silence. Mode and polarity act combinationally on the registered silence state. Each channel runs a three-state machine:

- ST_ACTIVE: the last valid sample was nonzero, or reset has just ended.
- ST_COUNTING: a run of zeros is in progress but is still shorter than `RUN_LEN`.
- ST_SILENT: `RUN_LEN` or more zeros in a row have been seen.

The machines move between these states as follows:

- ACTIVE→COUNTING on a valid zero sample.
- COUNTING→COUNTING on a valid zero sample while the run is still short.
- COUNTING→SILENT on the valid zero sample that completes the run.
- SILENT→SILENT on further zeros, with the counter held.
- Any state→ACTIVE on a valid nonzero sample.
- Any state→ACTIVE on synchronous reset.
- Every state holds while the strobe is low.

Top module: `silence_detect_top`

## Requirements
- R1: A channel becomes silent on the clock edge that accepts its `RUN_LEN`-th consecutive valid zero sample (default 1024), so its flag is visible in the following cycle. After `RUN_LEN`-1 zeros the channel is still not silent.
- R2: A valid nonzero sample on a channel clears that channel's run. The channel becomes not silent at the edge that accepts the sample, and counting restarts from the next zero.
- R3: Samples presented while `smp_valid` is 0 are ignored. They neither break nor extend a run.
- R4: With `flag_mode`=0, `flag_l` reports left-channel silence and `flag_r` reports right-channel silence, independently of each other.
- R5: With `flag_mode`=1, both flags carry one value. That value is the silent indication only when both channels are silent.
- R6: With `flag_inv`=0, a flag is 1 for silence. With `flag_inv`=1, both flags are inverted, and the change takes effect in the same cycle.
- R7: The run counter saturates. A channel stays silent through any number of further zero samples, for example 3000.
- R8: Synchronous reset puts both channels in the not-silent state with cleared counts. With `flag_inv`=0, both flags then read 0.
- R9: Each channel is tracked on its own. A nonzero sample on one channel does not disturb the other channel's run or its silence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Frame strobe; the left and right words are taken when it is 1 |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| flag_mode | input | 1 | 0: per-channel flags; 1: joint both-silent flag on both lines |
| flag_inv | input | 1 | 0: flag high means silent; 1: flag low means silent |
| flag_l | output | 1 | Left (or joint) silence flag |
| flag_r | output | 1 | Right (or joint) silence flag |

## Verification
Two functions can fall on one strobe. The left channel can complete its zero run in the same strobe that carries a nonzero right sample. That single edge then sends the left machine COUNTING→SILENT and the right machine to ACTIVE. The bench provokes this by sending `RUN_LEN`-1 zeros on both channels and then one frame with a zero on the left and a nonzero value on the right. It then expects the left flag to rise and the right flag to stay low in per-channel mode, and both flags to stay low in joint mode.

// File: rtl/silence_pkg.sv
package silence_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_COUNTING = 2'd1,
        ST_SILENT   = 2'd2
    } chan_state_t;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_L   = 0;
    localparam int unsigned CH_R   = 1;

endpackage

// File: rtl/silence_chan_fsm.sv
module silence_chan_fsm
    import silence_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp,
    output logic                silent
);
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

    chan_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             is_zero;

    assign is_zero = (smp == '0);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_ACTIVE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and run count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (smp_valid) begin
            if (!is_zero) begin
                st_d  = ST_ACTIVE;
                cnt_d = '0;
            end else begin
                unique case (st_q)
                    ST_ACTIVE: begin
                        st_d  = ST_COUNTING;
                        cnt_d = ONE;
                    end
                    ST_COUNTING: begin
                        cnt_d = cnt_q + ONE;
                        if (cnt_q == LAST_SHORT) begin
                            st_d = ST_SILENT;
                        end
                    end
                    ST_SILENT: begin
                        cnt_d = cnt_q;
                    end
                    default: begin
                        st_d  = ST_ACTIVE;
                        cnt_d = '0;
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        silent = (st_q == ST_SILENT);
    end

endmodule

// File: rtl/silence_flag_map.sv
module silence_flag_map (
    input  logic sil_l,
    input  logic sil_r,
    input  logic flag_mode,
    input  logic flag_inv,
    output logic flag_l,
    output logic flag_r
);
    logic raw_l, raw_r;

    always_comb begin
        unique case (flag_mode)
            1'b0: begin
                raw_l = sil_l;
                raw_r = sil_r;
            end
            1'b1: begin
                raw_l = sil_l & sil_r;
                raw_r = sil_l & sil_r;
            end
            default: begin
                raw_l = 1'b0;
                raw_r = 1'b0;
            end
        endcase
        flag_l = raw_l ^ flag_inv;
        flag_r = raw_r ^ flag_inv;
    end

endmodule

// File: rtl/silence_detect_top.sv
module silence_detect_top
    import silence_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                flag_mode,
    input  logic                flag_inv,
    output logic                flag_l,
    output logic                flag_r
);
    logic [SAMPLE_W-1:0] ch_smp [NUM_CH];
    logic [NUM_CH-1:0]   chan_silent;

    assign ch_smp[CH_L] = smp_left;
    assign ch_smp[CH_R] = smp_right;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        silence_chan_fsm #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN)
        ) chan_i (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (smp_valid),
            .smp       (ch_smp[c]),
            .silent    (chan_silent[c])
        );
    end

    silence_flag_map map_i (
        .sil_l     (chan_silent[CH_L]),
        .sil_r     (chan_silent[CH_R]),
        .flag_mode (flag_mode),
        .flag_inv  (flag_inv),
        .flag_l    (flag_l),
        .flag_r    (flag_r)
    );

endmodule

// File: rtl/silence_detect_chk.sv
module silence_detect_chk #(
    parameter int unsigned SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_left,
    input logic [SAMPLE_W-1:0] smp_right,
    input logic                flag_mode,
    input logic                flag_inv,
    input logic                flag_l,
    input logic                flag_r,
    input logic [1:0]          silent
);
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (silent == 2'b00));

    a_r2_nonzero_clears_left: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_left != '0) |=> !silent[0]);

    a_r2_nonzero_clears_right: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_right != '0) |=> !silent[1]);

    a_r1_rise_needs_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(silent[0]) |-> $past(smp_valid && smp_left == '0));

    a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(silent));

    a_r7_stays_silent: assert property (@(posedge clk) disable iff (rst)
        (silent[1] && !(smp_valid && smp_right != '0)) |=> silent[1]);

    a_r5_joint_equal: assert property (@(posedge clk) disable iff (rst)
        flag_mode |-> (flag_l == flag_r));

    a_r4_left_flag_drops: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_left != '0 && !flag_mode && !flag_inv
         && $stable(flag_mode) && $stable(flag_inv)) |=> (!flag_l || flag_mode || flag_inv));

endmodule

bind silence_detect_top silence_detect_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .flag_mode (flag_mode),
    .flag_inv  (flag_inv),
    .flag_l    (flag_l),
    .flag_r    (flag_r),
    .silent    (chan_silent)
);

// File: tb/silence_detect_top_tb_top.sv
module silence_detect_top_tb_top;
    localparam int SW  = 24;
    localparam int RUN = 1024;
    localparam int NV  = 10;

    // entry: {zeros_l[10:0], zeros_r[10:0], mode, inv, exp_l, exp_r}
    localparam logic [25:0] VEC [NV] = '{
        {11'd1024, 11'd1024, 1'b0, 1'b0, 1'b1, 1'b1},
        {11'd1023, 11'd1024, 1'b0, 1'b0, 1'b0, 1'b1},
        {11'd1024, 11'd1023, 1'b0, 1'b0, 1'b1, 1'b0},
        {11'd1024, 11'd1023, 1'b1, 1'b0, 1'b0, 1'b0},
        {11'd1024, 11'd1024, 1'b1, 1'b0, 1'b1, 1'b1},
        {11'd1024, 11'd0,    1'b0, 1'b1, 1'b0, 1'b1},
        {11'd1024, 11'd1024, 1'b1, 1'b1, 1'b0, 1'b0},
        {11'd0,    11'd1024, 1'b1, 1'b1, 1'b1, 1'b1},
        {11'd1500, 11'd200,  1'b0, 1'b0, 1'b1, 1'b0},
        {11'd1023, 11'd1023, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_left  = '0;
    logic [SW-1:0] smp_right = '0;
    logic          flag_mode = 1'b0;
    logic          flag_inv  = 1'b0;
    logic          flag_l, flag_r;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    silence_detect_top #(.SAMPLE_W(SW), .RUN_LEN(RUN)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .flag_mode (flag_mode),
        .flag_inv  (flag_inv),
        .flag_l    (flag_l),
        .flag_r    (flag_r)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: flags got=%b expected=%b", req, got, exp);
        end
    endtask

    // one frame accepted at the next rising edge
    task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
    endtask

    // idle cycle carrying junk that must be ignored (R3)
    task automatic gap();
        @(negedge clk);
        smp_valid = 1'b0;
        smp_left  = 24'h5A5A5A;
        smp_right = 24'h123456;
    endtask

    // finish the last frame and land at a negedge after its edge
    task automatic settle();
        @(negedge clk);
        smp_valid = 1'b0;
        smp_left  = '0;
        smp_right = '0;
    endtask

    task automatic run_zeros(input int nl, input int nr, input bit gaps);
        int n;
        n = (nl > nr) ? nl : nr;
        send(24'h000001, 24'hFFFFFF);
        for (int k = 0; k < n; k++) begin
            if (gaps && (k % 5 == 4)) gap();
            send((k >= n - nl) ? '0 : SW'(k + 7), (k >= n - nr) ? '0 : SW'(k + 3));
        end
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset flags low", {flag_l, flag_r}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after release", {flag_l, flag_r}, 2'b00);

        // table walk (R1 R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            flag_mode = 1'b0;
            flag_inv  = 1'b0;
            run_zeros(int'(VEC[i][25:15]), int'(VEC[i][14:4]), 1'b1);
            flag_mode = VEC[i][3];
            flag_inv  = VEC[i][2];
            #1;
            check($sformatf("R4/R5/R6/R3 vector %0d", i), {flag_l, flag_r}, VEC[i][1:0]);
        end
        flag_mode = 1'b0;
        flag_inv  = 1'b0;

        // R1 boundary: 1023 zeros not silent, 1024th makes it silent
        run_zeros(RUN - 1, RUN - 1, 1'b0);
        check("R1 after 1023 zeros", {flag_l, flag_r}, 2'b00);
        send('0, '0);
        settle();
        check("R1 after 1024 zeros", {flag_l, flag_r}, 2'b11);

        // R6 polarity acts in the same cycle
        flag_inv = 1'b1;
        #1;
        check("R6 inversion immediate", {flag_l, flag_r}, 2'b00);
        flag_inv = 1'b0;

        // R9 + R2: nonzero on left only
        send(24'h800000, '0);
        settle();
        check("R2 R9 left cleared right kept", {flag_l, flag_r}, 2'b01);
        // R2: count restarts
        for (int k = 0; k < RUN - 1; k++) send('0, '0);
        settle();
        check("R2 restart needs full run", {flag_l, flag_r}, 2'b01);
        send('0, '0);
        settle();
        check("R2 restart completes", {flag_l, flag_r}, 2'b11);

        // R7 saturation over 3000 more zeros
        for (int k = 0; k < 3000; k++) send('0, '0);
        settle();
        check("R7 still silent after 3000", {flag_l, flag_r}, 2'b11);

        // same-strobe: left completes run while right gets nonzero
        run_zeros(RUN - 1, RUN - 1, 1'b0);
        send('0, 24'h000005);
        settle();
        check("R4 coincident per-channel", {flag_l, flag_r}, 2'b10);
        flag_mode = 1'b1;
        #1;
        check("R5 coincident joint", {flag_l, flag_r}, 2'b00);
        flag_mode = 1'b0;

        // R8 reset during silence
        run_zeros(RUN, RUN, 1'b0);
        check("R8 pre-reset silent", {flag_l, flag_r}, 2'b11);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset clears silence", {flag_l, flag_r}, 2'b00);
        for (int k = 0; k < RUN - 1; k++) send('0, '0);
        settle();
        check("R8 count cleared by reset", {flag_l, flag_r}, 2'b00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule